// File: doc/BRIEF.md
# NAND Flash Command Interface Sequencer

This block is the device-side front end of a two-plane NAND flash part, cut down so it can be built and tested on its own. It watches the 8-bit shared bus and the two latch enables. On each rising edge of the write strobe it sorts the bus cycle into a command, an address or a data byte, and it tracks the two-phase sequences for page read, page program, block erase, column jumps, status, identification and abort. The real cell array, the analog timing and power-on lockout are not modelled. Busy times are fixed clock-cycle counts set by parameters, and one small page buffer (a power of two in size) stands in for the page register.

All strobes are sampled on a fast system clock. The read strobe drains the page buffer through a column pointer that steps by one and wraps at the page end. After a program or erase, the bus shows the status byte until a new command changes the output source. A multiplane program is taken as a first-plane load closed by a plane-hold confirm, then a second-plane load closed by the normal program confirm.

Top module: `nand_cmd_seq`

## Requirements
- R1: On a rising edge of `we_n`, the byte on `io_in` is a command when `cle`=1 and `ale`=0, an address when `ale`=1, and a data byte when both are 0.
- R2: Command 00h, five address cycles (two column bytes, low first, then three row bytes), then 30h: `rdy` is low for READ_BUSY clock cycles counted from the confirm edge, and the read column is the one given in the address.
- R3: While ready in page-output mode, each falling edge of `re_n` puts the buffer byte at the column pointer on `io_out` and advances the pointer, wrapping from PAGE_BYTES-1 to 0. A falling edge of `re_n` while busy changes nothing.
- R4: Command 05h, two column cycles, then E0h moves the read pointer inside the loaded page. This is accepted any number of times while in page-output mode.
- R5: Command 80h, five address cycles, data bytes (stored at successive columns), then 10h starts a program: `rdy` is low for PROG_BUSY cycles and the output shows status. Command 85h with two column cycles moves the load pointer in the middle of a load.
- R6: Command 60h, exactly three row cycles, then D0h starts an erase: `rdy` is low for ERASE_BUSY cycles and the output shows status.
- R7: Plane select is bit 6 of the first row byte. Confirm 11h is taken only after a complete load whose plane bit is 0. The following 10h starts the program only if the second load's plane bit is 1. Otherwise that 10h is dropped.
- R8: In status mode `io_out` = {write-protect state one cycle late (1 = writable), ready, ready, 4'b0000, fail}.
- R9: With `wp_n`=0, a program or erase confirm starts nothing (`rdy` stays high), sets the fail bit (bit 0) and selects status. A confirm that does start an operation clears the fail bit.
- R10: A confirm without its setup code, or after the wrong number of address cycles, is dropped: no busy period, no mode change, and the sequence returns to idle.
- R11: Command 90h followed by address 20h selects ID mode. Successive `re_n` falling edges give 4Fh, 4Eh, 46h, 49h, then repeat.
- R12: Command FFh at any time ends the busy period (ready on the next cycle), clears fail and any pending sequence, and selects status. While busy, every other command except 70h is ignored. 70h selects status at any time.
- R13: After reset `rdy`=1 and `io_out`=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst | input | 1 | Synchronous active-high reset |
| cle | input | 1 | Command-latch enable |
| ale | input | 1 | Address-latch enable |
| we_n | input | 1 | Write strobe, active low, latches on its rising edge |
| re_n | input | 1 | Read strobe, active low, advances on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte driven by the host |
| io_out | output | 8 | Bus byte returned to the host |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
A wrong sequence state shows up in the clock cycle after the confirm or read strobe that depends on it. Either `rdy` falls when it should not (or fails to fall), or the next `re_n` edge returns a byte from the wrong column or source. A wrong busy counter shifts the rising edge of `rdy` and ready bit 6 of the status byte by the same number of cycles. A lost fail or write-protect bit is seen as soon as status mode is selected. Comparing both outputs on every clock bounds the detection delay to one cycle after the stimulus that exposes the fault.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {M_IDLE, M_STAT, M_DATA, M_ID} mode_e;
  typedef enum logic [2:0] {P_NONE, P_READ, P_COLRD, P_PROG, P_COLWR, P_ERASE, P_ID} pend_e;

  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_READ_GO  = 8'h30;
  localparam logic [7:0] OP_JUMP_RD  = 8'h05;
  localparam logic [7:0] OP_JUMP_GO  = 8'hE0;
  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_JUMP_WR  = 8'h85;
  localparam logic [7:0] OP_PROG_GO  = 8'h10;
  localparam logic [7:0] OP_PLANE_GO = 8'h11;
  localparam logic [7:0] OP_ERASE    = 8'h60;
  localparam logic [7:0] OP_ERASE_GO = 8'hD0;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_ABORT    = 8'hFF;
  localparam logic [7:0] IDENT_ADDR  = 8'h20;

  function automatic logic [7:0] ident_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h4F;
      2'd1:    return 8'h4E;
      2'd2:    return 8'h46;
      default: return 8'h49;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic wp, input logic ready, input logic fail);
    return {wp, ready, ready, 4'b0000, fail};
  endfunction

endpackage

// File: rtl/nand_edge_det.sv
module nand_edge_det #(
  parameter bit DET_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strobe;
  end

  generate
    if (DET_RISE) begin : g_rise
      assign pulse = strobe & ~prev_q;
    end else begin : g_fall
      assign pulse = ~strobe & prev_q;
    end
  endgenerate
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] value,
  input  logic          clear,
  output logic          ready
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)        cnt_q <= '0;
    else if (load)           cnt_q <= value;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 8'h00;
    else if (rd) rdata <= mem[addr];
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int READ_BUSY  = 12,
  parameter int PROG_BUSY  = 20,
  parameter int ERASE_BUSY = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       rdy
);
  localparam int CW   = $clog2(PAGE_BYTES);
  localparam int TMAX = (READ_BUSY > PROG_BUSY) ?
                        ((READ_BUSY > ERASE_BUSY) ? READ_BUSY : ERASE_BUSY) :
                        ((PROG_BUSY > ERASE_BUSY) ? PROG_BUSY : ERASE_BUSY);
  localparam int TW   = $clog2(TMAX + 1);
  typedef logic [CW-1:0] col_t;

  logic we_rise, re_fall, cmd_ev, adr_ev, dat_ev, load_done;
  logic t_load, t_clr, mem_we, mem_re;
  logic [TW-1:0] t_val;
  logic [7:0] buf_q, id_q, id_d, lo_q, lo_d;
  mode_e mode_q, mode_d;
  pend_e pend_q, pend_d;
  logic [2:0] acnt_q, acnt_d;
  col_t col_q, col_d, col_inc;
  logic plane_q, plane_d, mp_q, mp_d, fail_q, fail_d, wp_q;
  logic [1:0] idx_q, idx_d;

  nand_edge_det #(.DET_RISE(1'b1)) u_we (.clk(clk), .rst(rst), .strobe(we_n), .pulse(we_rise));
  nand_edge_det #(.DET_RISE(1'b0)) u_re (.clk(clk), .rst(rst), .strobe(re_n), .pulse(re_fall));

  nand_busy_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .value(t_val), .clear(t_clr), .ready(rdy));

  nand_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst(rst), .wr(mem_we), .rd(mem_re), .addr(col_q), .wdata(io_in), .rdata(buf_q));

  assign cmd_ev    = we_rise & cle & ~ale;
  assign adr_ev    = we_rise & ale;
  assign dat_ev    = we_rise & ~cle & ~ale;
  assign load_done = (pend_q == P_PROG && acnt_q == 3'd5) || (pend_q == P_COLWR && acnt_q == 3'd2);
  assign col_inc   = (col_q == col_t'(PAGE_BYTES - 1)) ? '0 : col_q + 1'b1;

  always_comb begin
    mode_d = mode_q; pend_d = pend_q; acnt_d = acnt_q; col_d = col_q; lo_d = lo_q;
    plane_d = plane_q; mp_d = mp_q; fail_d = fail_q; idx_d = idx_q; id_d = id_q;
    t_load = 1'b0; t_clr = 1'b0; t_val = '0; mem_we = 1'b0; mem_re = 1'b0;
    if (cmd_ev) begin
      if (io_in == OP_ABORT) begin
        t_clr = 1'b1; pend_d = P_NONE; acnt_d = '0; mp_d = 1'b0; fail_d = 1'b0; mode_d = M_STAT;
      end else if (io_in == OP_STATUS) begin
        mode_d = M_STAT;
      end else if (rdy) begin
        pend_d = P_NONE;
        acnt_d = '0;
        case (io_in)
          OP_READ:    pend_d = P_READ;
          OP_JUMP_RD: pend_d = (mode_q == M_DATA) ? P_COLRD : P_NONE;
          OP_LOAD:    pend_d = P_PROG;
          OP_JUMP_WR: pend_d = load_done ? P_COLWR : P_NONE;
          OP_ERASE:   pend_d = P_ERASE;
          OP_IDENT:   pend_d = P_ID;
          OP_READ_GO: if (pend_q == P_READ && acnt_q == 3'd5) begin
            t_load = 1'b1; t_val = TW'(READ_BUSY); mode_d = M_DATA;
          end
          OP_JUMP_GO: if (pend_q == P_COLRD && acnt_q == 3'd2) mode_d = M_DATA;
          OP_PROG_GO: begin
            if (load_done && (!mp_q || plane_q)) begin
              mode_d = M_STAT;
              fail_d = ~wp_n;
              if (wp_n) begin t_load = 1'b1; t_val = TW'(PROG_BUSY); end
            end
            mp_d = 1'b0;
          end
          OP_PLANE_GO: mp_d = load_done && !mp_q && !plane_q;
          OP_ERASE_GO: if (pend_q == P_ERASE && acnt_q == 3'd3) begin
            mode_d = M_STAT;
            fail_d = ~wp_n;
            if (wp_n) begin t_load = 1'b1; t_val = TW'(ERASE_BUSY); end
          end
          default: ;
        endcase
      end
    end else if (adr_ev && rdy && pend_q != P_NONE) begin
      if (pend_q == P_ID) begin
        if (io_in == IDENT_ADDR) begin mode_d = M_ID; idx_d = '0; end
        pend_d = P_NONE;
      end else begin
        acnt_d = (acnt_q == 3'd7) ? acnt_q : acnt_q + 1'b1;
        if (acnt_q == 3'd0) lo_d = io_in;
        if (acnt_q == 3'd1 && pend_q != P_ERASE) col_d = col_t'({io_in, lo_q});
        if (acnt_q == 3'd2 && pend_q == P_PROG) plane_d = io_in[6];
      end
    end else if (dat_ev && rdy && load_done) begin
      mem_we = 1'b1; col_d = col_inc;
    end else if (re_fall && rdy) begin
      if (mode_q == M_DATA) begin
        mem_re = 1'b1; col_d = col_inc;
      end else if (mode_q == M_ID) begin
        id_d = ident_byte(idx_q); idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_IDLE; pend_q <= P_NONE; acnt_q <= '0; col_q <= '0; lo_q <= '0;
      plane_q <= 1'b0; mp_q <= 1'b0; fail_q <= 1'b0; idx_q <= '0; id_q <= '0; wp_q <= 1'b1;
    end else begin
      mode_q <= mode_d; pend_q <= pend_d; acnt_q <= acnt_d; col_q <= col_d; lo_q <= lo_d;
      plane_q <= plane_d; mp_q <= mp_d; fail_q <= fail_d; idx_q <= idx_d; id_q <= id_d;
      wp_q <= wp_n;
    end
  end

  always_comb begin
    case (mode_q)
      M_STAT:  io_out = status_byte(wp_q, rdy, fail_q);
      M_DATA:  io_out = buf_q;
      M_ID:    io_out = id_q;
      default: io_out = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk
  import nand_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       wp_n,
  input logic [7:0] io_in,
  input logic [7:0] io_out,
  input logic       rdy,
  input mode_e      mode_q
);
  AST_BUSY_ONLY_FROM_CONFIRM: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> ($past(we_n) && !$past(we_n, 2) && $past(cle) && !$past(ale) &&
                    ($past(io_in) == 8'h30 || $past(io_in) == 8'h10 || $past(io_in) == 8'hD0))); // R2

  AST_STATUS_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_STAT) |-> (io_out[6] == rdy && io_out[5] == rdy && io_out[4:1] == 4'b0000 &&
                            io_out[7] == $past(wp_n))); // R8

  AST_PROTECT_NO_START: assert property (@(posedge clk) disable iff (rst)
    ($past(we_n) && !$past(we_n, 2) && $past(cle) && !$past(ale) && !$past(wp_n) && $past(rdy) &&
     ($past(io_in) == 8'h10 || $past(io_in) == 8'hD0)) |-> rdy); // R9

  AST_OUTPUT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rdy) && mode_q == $past(mode_q) && mode_q != M_STAT) |-> $stable(io_out)); // R3
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk(clk), .rst(rst), .cle(cle), .ale(ale), .we_n(we_n), .wp_n(wp_n),
  .io_in(io_in), .io_out(io_out), .rdy(rdy), .mode_q(mode_q));

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
  localparam int PAGE = 16, RDB = 12, PGB = 20, ERB = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic rdy;

  always #2 clk = ~clk;

  nand_cmd_seq #(.PAGE_BYTES(PAGE), .READ_BUSY(RDB), .PROG_BUSY(PGB), .ERASE_BUSY(ERB)) u_dut (
    .clk(clk), .rst(rst), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .wp_n(wp_n),
    .io_in(io_in), .io_out(io_out), .rdy(rdy));

  int total = 0, bad = 0, cyc = 0;
  string req = "R13";
  bit started = 0;

  // behavioural reference: pending setup is kept as its opcode (-1 = none)
  int m_busy, m_mode, m_pend, m_acnt, m_col, m_lo, m_plane, m_mp, m_fail, m_wpq, m_idx;
  int m_prev_we, m_prev_re;
  logic [7:0] m_bufq, m_idq;
  logic [7:0] m_pg [PAGE];
  localparam logic [7:0] SIG [4] = '{8'h4F, 8'h4E, 8'h46, 8'h49};

  function automatic bit m_loaded();
    return (m_pend == 'h80 && m_acnt == 5) || (m_pend == 'h85 && m_acnt == 2);
  endfunction

  function automatic logic [7:0] m_out();
    logic r;
    r = (m_busy == 0);
    case (m_mode)
      1: return {m_wpq[0], r, r, 4'b0, m_fail[0]};
      2: return m_bufq;
      3: return m_idq;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_mode = 0; m_pend = -1; m_acnt = 0; m_col = 0; m_lo = 0; m_plane = 0;
      m_mp = 0; m_fail = 0; m_wpq = 1; m_idx = 0; m_bufq = 0; m_idq = 0;
      m_prev_we = 1; m_prev_re = 1;
    end else begin
      automatic bit wr = we_n && !m_prev_we;
      automatic bit rf = !re_n && m_prev_re;
      automatic bit ready = (m_busy == 0);
      automatic int op = io_in;
      if (m_busy > 0) m_busy--;
      if (wr && cle && !ale) begin
        if (op == 'hFF) begin
          m_busy = 0; m_pend = -1; m_acnt = 0; m_mp = 0; m_fail = 0; m_mode = 1;
        end else if (op == 'h70) m_mode = 1;
        else if (ready) begin
          automatic bit done = m_loaded();
          automatic int p = m_pend, n = m_acnt;
          m_pend = -1; m_acnt = 0;
          if (op == 'h00 || op == 'h80 || op == 'h60 || op == 'h90) m_pend = op;
          else if (op == 'h05) m_pend = (m_mode == 2) ? op : -1;
          else if (op == 'h85) m_pend = done ? op : -1;
          else if (op == 'h30) begin
            if (p == 'h00 && n == 5) begin m_busy = RDB; m_mode = 2; end
          end else if (op == 'hE0) begin
            if (p == 'h05 && n == 2) m_mode = 2;
          end else if (op == 'h10) begin
            if (done && (m_mp == 0 || m_plane == 1)) begin
              m_mode = 1; m_fail = !wp_n;
              if (wp_n) m_busy = PGB;
            end
            m_mp = 0;
          end else if (op == 'h11) m_mp = (done && m_mp == 0 && m_plane == 0);
          else if (op == 'hD0) begin
            if (p == 'h60 && n == 3) begin
              m_mode = 1; m_fail = !wp_n;
              if (wp_n) m_busy = ERB;
            end
          end
        end
      end else if (wr && ale && ready && m_pend != -1) begin
        if (m_pend == 'h90) begin
          if (op == 'h20) begin m_mode = 3; m_idx = 0; end
          m_pend = -1;
        end else begin
          if (m_acnt == 0) m_lo = op;
          if (m_acnt == 1 && m_pend != 'h60) m_col = (op * 256 + m_lo) % PAGE;
          if (m_acnt == 2 && m_pend == 'h80) m_plane = op[6];
          if (m_acnt < 7) m_acnt++;
        end
      end else if (wr && !cle && !ale && ready && m_loaded()) begin
        m_pg[m_col] = io_in; m_col = (m_col + 1) % PAGE;
      end else if (rf && ready) begin
        if (m_mode == 2) begin m_bufq = m_pg[m_col]; m_col = (m_col + 1) % PAGE; end
        else if (m_mode == 3) begin m_idq = SIG[m_idx]; m_idx = (m_idx + 1) % 4; end
      end
      m_wpq = wp_n; m_prev_we = we_n; m_prev_re = re_n;
      started = 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      total += 2;
      if (rdy !== (m_busy == 0)) begin
        bad++; $display("FAIL %s rdy act=%0b exp=%0b t=%0t", req, rdy, (m_busy == 0), $time);
      end
      if (io_out !== m_out()) begin
        bad++; $display("FAIL %s io_out act=%02h exp=%02h t=%0t", req, io_out, m_out(), $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus(logic c, logic a, logic [7:0] b);
    cle = c; ale = a; io_in = b; we_n = 1'b0; tick();
    we_n = 1'b1; tick();
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b); bus(1'b1, 1'b0, b); endtask
  task automatic adr(logic [7:0] b); bus(1'b0, 1'b1, b); endtask
  task automatic dat(logic [7:0] b); bus(1'b0, 1'b0, b); endtask
  task automatic strobe_rd(); re_n = 1'b0; tick(); re_n = 1'b1; tick(); endtask
  task automatic addr5(logic [7:0] c0, logic [7:0] r0);
    adr(c0); adr(8'h00); adr(r0); adr(8'h00); adr(8'h00);
  endtask

  initial begin
    tick(4); rst = 1'b0; tick(2);                   // R13 reset state

    req = "R1"; cmd(8'h80); addr5(8'h00, 8'h00);    // R5 page load
    for (int i = 0; i < 8; i++) dat(8'h11 * (i + 1));
    req = "R5"; cmd(8'h85); adr(8'h0C); adr(8'h00); dat(8'hA5); dat(8'h5A);
    cmd(8'h10); tick(PGB + 4);

    req = "R2"; cmd(8'h00); addr5(8'h02, 8'h00); cmd(8'h30);
    req = "R3"; strobe_rd(); tick(RDB);             // strobe while busy is ignored
    for (int i = 0; i < 5; i++) strobe_rd();
    req = "R4"; cmd(8'h05); adr(8'h0C); adr(8'h00); cmd(8'hE0);
    for (int i = 0; i < 6; i++) strobe_rd();        // R3 wrap past column 15
    cmd(8'h05); adr(8'h01); adr(8'h00); cmd(8'hE0); strobe_rd(); strobe_rd();

    req = "R6"; cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0); tick(3);
    req = "R12"; cmd(8'h00); cmd(8'h70); tick(ERB);

    req = "R9"; wp_n = 1'b0; tick(2); cmd(8'h80); addr5(8'h00, 8'h00); cmd(8'h10); tick(3);
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0); tick(2);
    req = "R8"; wp_n = 1'b1; tick(3); cmd(8'h70); tick(2);

    req = "R7"; cmd(8'h80); addr5(8'h00, 8'h00); dat(8'h77); cmd(8'h11);
    cmd(8'h80); addr5(8'h00, 8'h40); dat(8'h88); cmd(8'h10); tick(PGB + 2);
    cmd(8'h80); addr5(8'h00, 8'h40); cmd(8'h11); cmd(8'h70); tick(2);
    cmd(8'h80); addr5(8'h00, 8'h00); cmd(8'h11);
    cmd(8'h80); addr5(8'h00, 8'h00); cmd(8'h10); tick(3);

    req = "R10"; cmd(8'h30); cmd(8'hD0); cmd(8'h10); cmd(8'hE0);
    cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'hD0);
    cmd(8'h00); adr(8'h00); adr(8'h00); cmd(8'h30); tick(3);

    req = "R11"; cmd(8'h90); adr(8'h20);
    for (int i = 0; i < 5; i++) strobe_rd();
    cmd(8'h90); adr(8'h00); strobe_rd();

    req = "R12"; wp_n = 1'b0; tick(1);
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0); wp_n = 1'b1; tick(1);
    cmd(8'h80); addr5(8'h00, 8'h00); cmd(8'h10); tick(4); cmd(8'hFF); tick(4);
    cmd(8'h00); addr5(8'h00, 8'h00); cmd(8'h30); tick(2); cmd(8'hFF); tick(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule